// File: doc/BRIEF.md
# Shared-Half-Adder Carry Select Adder

A purely combinational binary adder of parameterised width that adds two operands and a one-bit carry-in, giving a sum of the same width and a carry-out. A single row of half adders turns each operand bit pair into a bit-level difference term (XOR) and a bit-level generate term (AND). Two speculative carry chains read that one row. One chain assumes an incoming carry of zero and the other assumes one. Each chain finishes the full-adder job in its own second half-adder stage.

When the real carry-in arrives, a final selector picks the sum bits and the carry-out from the matching chain. The carry-in therefore never ripples: it only steers a row of 2:1 selectors. Because the half-adder row is shared rather than duplicated, both speculative results cost one XOR/AND pair per bit less than two independent ripple adders. The block suits any datapath that needs a small, late-carry-tolerant adder with no clock or reset.

Top module: `csa_shared_ha_adder`

## Requirements
- R1: For operands with no bit set in both (a AND b is zero), the sum equals a OR b and cout is 0, because each half-adder bit gives a XOR b as its sum term and a AND b as its carry term.
- R2: With cin = 0, {cout, sum} equals a + b. This is the result of the chain that assumes a zero carry into bit 0.
- R3: With cin = 1, {cout, sum} equals a + b + 1. This is the result of the chain that assumes a one carry into bit 0.
- R4: Inside each chain, the carry into bit i+1 is (sum term i AND carry into bit i) OR carry term i. A carry therefore propagates through a run of bits where a XOR b is 1, for example 0x00FF + 0x0001 = 0x0100.
- R5: Each sum bit is taken from the zero-assuming chain when cin is 0 and from the one-assuming chain when cin is 1.
- R6: cout is selected by cin from the two chains' final carries in the same way as the sum bits.
- R7: For every input combination, {cout, sum} equals a + b + cin. The WIDTH parameter defaults to 16 and must be at least 2.
- R8: All-ones operands with cin = 1 give a sum of all ones and cout = 1. Zero operands with cin = 0 give a sum of zero and cout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0; selects between the two chains |
| sum | output | WIDTH | Selected sum |
| cout | output | 1 | Selected carry out of the top bit |

## Verification
The two speculative chains are always active together, and the hardest case is when the carry-in selection and a full-length carry ripple coincide. This happens when a XOR b is all ones, where the two chains differ in every sum bit and in the carry-out. The bench provokes that case with complementary operands under both carry-in values, and with all-ones operands plus carry-in. It judges each output against an arithmetic sum computed in the bench. A four-bit instance is driven exhaustively, so every selection-and-ripple combination is covered at that width.

// File: rtl/csa_pkg.sv
package csa_pkg;
  parameter int unsigned CSA_DEFAULT_W = 16;
  parameter int unsigned CSA_MIN_W     = 2;
endpackage

// File: rtl/csa_half_row.sv
module csa_half_row #(
  parameter int unsigned WIDTH = csa_pkg::CSA_DEFAULT_W
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic [WIDTH-1:0] part_sum,
  output logic [WIDTH-1:0] part_carry
);
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_ha
    assign part_sum[gi]   = op_x[gi] ^ op_y[gi];
    assign part_carry[gi] = op_x[gi] & op_y[gi];
  end

  // A bit cannot both propagate and generate
  always_comb begin
    AST_HA_DISJOINT: assert ((part_sum & part_carry) == '0)
      else $error("half row terms overlap"); // R1
  end
endmodule

// File: rtl/csa_gen_chain.sv
module csa_gen_chain #(
  parameter int unsigned WIDTH     = csa_pkg::CSA_DEFAULT_W,
  parameter bit          CARRY_SEED = 1'b0
) (
  input  logic [WIDTH-1:0] part_sum,
  input  logic [WIDTH-1:0] part_carry,
  output logic [WIDTH-1:0] chain_sum,
  output logic             chain_cout
);
  // Second half-adder stage plus carry OR, rippled from a fixed seed (R4)
  always_comb begin
    logic carry_run;
    carry_run = CARRY_SEED;
    for (int i = 0; i < WIDTH; i++) begin
      chain_sum[i] = part_sum[i] ^ carry_run;
      carry_run    = (part_sum[i] & carry_run) | part_carry[i];
    end
    chain_cout = carry_run;
  end
endmodule

// File: rtl/csa_select_mux.sv
module csa_select_mux #(
  parameter int unsigned WIDTH = csa_pkg::CSA_DEFAULT_W
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] sum_lo,
  input  logic             cout_lo,
  input  logic [WIDTH-1:0] sum_hi,
  input  logic             cout_hi,
  output logic [WIDTH-1:0] sum_pick,
  output logic             cout_pick
);
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_mux
    assign sum_pick[gi] = (sum_lo[gi] & ~sel) | (sum_hi[gi] & sel);
  end
  assign cout_pick = (cout_lo & ~sel) | (cout_hi & sel);
endmodule

// File: rtl/csa_shared_ha_adder.sv
module csa_shared_ha_adder #(
  parameter int unsigned WIDTH = csa_pkg::CSA_DEFAULT_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned EXT_W = WIDTH + 1;

  if (WIDTH < csa_pkg::CSA_MIN_W) begin : g_width_check
    $error("csa_shared_ha_adder: WIDTH must be at least 2");
  end

  logic [WIDTH-1:0] hs, hc;
  logic [WIDTH-1:0] s_zero, s_one;
  logic             c_zero, c_one;

  csa_half_row #(.WIDTH(WIDTH)) u_half_row (
    .op_x(a), .op_y(b), .part_sum(hs), .part_carry(hc)
  );

  csa_gen_chain #(.WIDTH(WIDTH), .CARRY_SEED(1'b0)) u_chain_zero (
    .part_sum(hs), .part_carry(hc), .chain_sum(s_zero), .chain_cout(c_zero)
  );

  csa_gen_chain #(.WIDTH(WIDTH), .CARRY_SEED(1'b1)) u_chain_one (
    .part_sum(hs), .part_carry(hc), .chain_sum(s_one), .chain_cout(c_one)
  );

  csa_select_mux #(.WIDTH(WIDTH)) u_select (
    .sel(cin),
    .sum_lo(s_zero), .cout_lo(c_zero),
    .sum_hi(s_one),  .cout_hi(c_one),
    .sum_pick(sum),  .cout_pick(cout)
  );

  always_comb begin
    AST_ZERO_CHAIN_SUM: assert ({c_zero, s_zero} == (EXT_W'(a) + EXT_W'(b)))
      else $error("zero-seed chain wrong"); // R2
    AST_ONE_CHAIN_STEP: assert ({c_one, s_one} == ({c_zero, s_zero} + EXT_W'(1)))
      else $error("one-seed chain not one above zero-seed chain"); // R3
    AST_TOTAL_EXACT: assert ({cout, sum} == (EXT_W'(a) + EXT_W'(b) + EXT_W'(cin)))
      else $error("selected result wrong"); // R7
    AST_COUT_PICK: assert (cout == (cin ? c_one : c_zero))
      else $error("carry-out from wrong chain"); // R6
  end
endmodule

// File: tb/test_csa_shared_ha_adder.sv
module test_csa_shared_ha_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int WS = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a, b, sum;
  logic          cin, cout;
  logic [WS-1:0] sa, sb, ssum;
  logic          scin, scout;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  csa_shared_ha_adder #(.WIDTH(W)) i_csa_shared_ha_adder (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );
  csa_shared_ha_adder #(.WIDTH(WS)) i_csa_small (
    .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout)
  );

  task automatic apply_check(input logic [W-1:0] xa, input logic [W-1:0] xb,
                             input logic xc, input string req);
    logic [W:0] exp;
    a = xa; b = xb; cin = xc;
    #(CLK_PERIOD/2);
    exp = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
    n_run++;
    if ({cout, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", req, xa, xb, xc,
               {cout, sum}, exp);
    end
  endtask

  task automatic t_reset_state();   // R8 zero case
    apply_check('0, '0, 1'b0, "R8");
  endtask

  task automatic t_disjoint();      // R1
    apply_check(16'hA0A0, 16'h0505, 1'b0, "R1");
    apply_check(16'hF000, 16'h0F0F, 1'b0, "R1");
  endtask

  task automatic t_zero_chain();    // R2, R5
    apply_check(16'h1234, 16'h4321, 1'b0, "R2");
    apply_check(16'h8000, 16'h8000, 1'b0, "R2");
    apply_check(16'h5555, 16'hAAAA, 1'b0, "R5");
  endtask

  task automatic t_one_chain();     // R3, R5
    apply_check(16'h1234, 16'h4321, 1'b1, "R3");
    apply_check(16'h5555, 16'hAAAA, 1'b1, "R5");
    apply_check(16'h0000, 16'h0000, 1'b1, "R3");
  endtask

  task automatic t_ripple();        // R4
    apply_check(16'h00FF, 16'h0001, 1'b0, "R4");
    apply_check(16'h0FFF, 16'h0000, 1'b1, "R4");
    apply_check(16'h7FFF, 16'h0001, 1'b0, "R4");
  endtask

  task automatic t_cout_select();   // R6
    apply_check(16'hFFFF, 16'h0000, 1'b0, "R6");
    apply_check(16'hFFFF, 16'h0000, 1'b1, "R6");
    apply_check(16'h8001, 16'h7FFF, 1'b0, "R6");
  endtask

  task automatic t_all_ones();      // R8
    apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R8");
    n_run++;
    if (sum !== 16'hFFFF || cout !== 1'b1) begin
      n_fail++;
      $display("FAIL R8: got %b_%h expected 1_ffff", cout, sum);
    end
  endtask

  task automatic t_random();        // R7 at width 16
    for (int k = 0; k < 3000; k++) begin
      apply_check(W'($urandom), W'($urandom), 1'($urandom), "R7");
    end
  endtask

  task automatic t_exhaustive();    // R7 at width 4
    for (int x = 0; x < (1 << WS); x++) begin
      for (int y = 0; y < (1 << WS); y++) begin
        for (int c = 0; c < 2; c++) begin
          logic [WS:0] exp;
          sa = WS'(x); sb = WS'(y); scin = 1'(c);
          #(CLK_PERIOD/2);
          exp = (WS+1)'(x) + (WS+1)'(y) + (WS+1)'(c);
          n_run++;
          if ({scout, ssum} !== exp) begin
            n_fail++;
            $display("FAIL R7: a=%h b=%h cin=%0d got %h expected %h",
                     x, y, c, {scout, ssum}, exp);
          end
        end
      end
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    sa = '0; sb = '0; scin = 1'b0;
    #(CLK_PERIOD);
    t_reset_state();
    t_disjoint();
    t_zero_chain();
    t_one_chain();
    t_ripple();
    t_cout_select();
    t_all_ones();
    t_exhaustive();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule